// File: doc/BRIEF.md
# Clock Mode Select and Power-Down Gate

This block sits between the frequency synthesiser of a system clock generator and its output pads. It receives the already-generated source clocks and a separate test clock, and it delivers the system clock outputs. These are the host CPU clock, eight switchable memory clocks, one free-running memory clock, the hub clock, the PCI clock, the 48 MHz clock, the reference clock and the interrupt-controller (APIC) clock. A two-bit frequency-select input chooses between three behaviours. The first turns off the pad drivers. The second is a test mode, in which every output is a fixed power-of-two division of the test clock. The third is normal operation, with either a 66 MHz or a 100 MHz CPU source.

An active-low, asynchronous power-down request is brought into the CPU clock domain and qualified before it takes effect. Each output then stops low at its own next falling edge, so no output emits a shortened high pulse. While power-down is in force, the oscillator-stop and VCO-stop outputs are raised. A strap input, captured once after reset, selects whether the APIC clock runs at the PCI rate or at half of it.

All control inputs are plain level signals. There is no data stream at this block's edge, so no valid/ready handshake applies.

Top module: `clk_mode_gate`

## Requirements
- R1: While `rst_n` is low, every clock output and both stop outputs are low.
- R2: `clk_oe` is low when `freq_sel` is 2'b00 (the pads float) and high for 2'b01, 2'b10 and 2'b11.
- R3: With `freq_sel` = 2'b11, `cpu_clk` follows `src_cpu100`. With 2'b10, it follows `src_cpu66`. In both normal codes, the memory, hub, PCI, 48 MHz and reference outputs follow `src_sdram`, `src_hub`, `src_pci`, `src_usb` and `src_ref`.
- R4: With `freq_sel` = 2'b01, the outputs are divisions of `tclk`: cpu /2, memory /4, hub /4, PCI /8, 48 MHz /2, reference /1 and APIC /16.
- R5: `apic_strap` is captured at the first rising edge of `src_ref` after reset is released. A captured 1 makes the APIC output run at the `src_pci` rate, and a 0 makes it run at half that rate. Later changes to the strap have no effect until the next reset.
- R6: `pd_n` passes through a two-flop synchroniser clocked by the selected CPU source. Power-down is accepted only when the synchronised value is low on two consecutive CPU edges. Acceptance raises `osc_stop` and `vco_stop`, and the stop outputs stay low for at least the first three CPU edges after `pd_n` falls.
- R7: Once power-down is accepted, each output is held low from its own next falling edge. No output emits a high pulse shorter than its source's high phase.
- R8: After `pd_n` returns high, the stop outputs fall after the synchroniser delay, and each enabled output resumes at the first rising edge after its gate reopens.
- R9: `sdram_en[i]` = 1 lets `sdram_clk[i]` run, and 0 holds it low, including after power-down exit. `sdram_free_clk` ignores `sdram_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| tclk | input | 1 | Test clock, divided in test mode |
| src_cpu66 | input | 1 | 66 MHz CPU source |
| src_cpu100 | input | 1 | 100 MHz CPU source |
| src_sdram | input | 1 | Memory clock source |
| src_hub | input | 1 | Hub clock source |
| src_pci | input | 1 | PCI clock source, also the APIC base |
| src_usb | input | 1 | 48 MHz source |
| src_ref | input | 1 | Reference clock source |
| freq_sel | input | 2 | Mode select: 00 off, 01 test, 10 66 MHz, 11 100 MHz |
| apic_strap | input | 1 | APIC rate strap, captured after reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| sdram_en | input | NUM_SDRAM | Per-output enable for the switchable memory clocks |
| cpu_clk | output | 1 | CPU clock |
| sdram_clk | output | NUM_SDRAM | Switchable memory clocks |
| sdram_free_clk | output | 1 | Free-running memory clock |
| hub_clk | output | 1 | Hub clock |
| pci_clk | output | 1 | PCI clock |
| usb_clk | output | 1 | 48 MHz clock |
| ref_clk | output | 1 | Reference clock |
| apic_clk | output | 1 | APIC clock |
| clk_oe | output | 1 | Pad drive enable for all clock outputs |
| osc_stop | output | 1 | Crystal oscillator stop request |
| vco_stop | output | 1 | VCO stop request |

## Verification
The assertions assume three things about the inputs. The source clocks run freely. `freq_sel` is not changed while a power-down is in progress. `pd_n` never changes on the same instant as a CPU source edge, so the checker's samples and the synchroniser see the same value. The bench changes every input on a falling edge of `tclk`, at a whole nanosecond, and gives each source clock a fractional-nanosecond phase offset, so that no input change coincides with a source edge. Mode switches happen only while power-down is inactive, and the runt-pulse count is taken only over windows in which the mode stays fixed.

// File: rtl/clk_mode_gate_pkg.sv
package clk_mode_gate_pkg;

  typedef enum logic [1:0] {
    SEL_HIZ  = 2'b00,
    SEL_TEST = 2'b01,
    SEL_N66  = 2'b10,
    SEL_N100 = 2'b11
  } freq_sel_e;

  // test-clock divider depth; tap k carries tclk / 2**k
  localparam int DIV_STAGES = 4;

  localparam int TAP_CPU   = 1;
  localparam int TAP_SDRAM = 2;
  localparam int TAP_HUB   = 2;
  localparam int TAP_PCI   = 3;
  localparam int TAP_USB   = 1;
  localparam int TAP_REF   = 0;
  localparam int TAP_APIC  = 4;

  // fixed gate slots; switchable memory clocks follow after these
  localparam int N_FIXED   = 7;
  localparam int IDX_CPU   = 0;
  localparam int IDX_SDF   = 1;
  localparam int IDX_HUB   = 2;
  localparam int IDX_PCI   = 3;
  localparam int IDX_USB   = 4;
  localparam int IDX_REF   = 5;
  localparam int IDX_APIC  = 6;

endpackage

// File: rtl/clk_test_div.sv
module clk_test_div #(
  parameter int STAGES = clk_mode_gate_pkg::DIV_STAGES
) (
  input  logic              tclk,
  input  logic              rst_n,
  output logic [STAGES:0]   tap
);
  logic [STAGES-1:0] cnt;

  // binary counter: bit k toggles at tclk / 2**(k+1)
  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign tap = {cnt, tclk};
endmodule

// File: rtl/clk_src_select.sv
module clk_src_select
  import clk_mode_gate_pkg::*;
#(
  parameter int STAGES = DIV_STAGES
) (
  input  logic [1:0]        freq_sel,
  input  logic [STAGES:0]   tap,
  input  logic              src_cpu66,
  input  logic              src_cpu100,
  input  logic              src_sdram,
  input  logic              src_hub,
  input  logic              src_pci,
  input  logic              src_usb,
  input  logic              src_ref,
  input  logic              apic_norm,
  output logic              cpu_s,
  output logic              sd_s,
  output logic              hub_s,
  output logic              pci_s,
  output logic              usb_s,
  output logic              ref_s,
  output logic              apic_s
);
  logic test_mode;
  assign test_mode = (freq_sel == SEL_TEST);

  // static-select clock muxes; selects are expected to be quiet
  always_comb begin
    if (test_mode) begin
      cpu_s  = tap[TAP_CPU];
      sd_s   = tap[TAP_SDRAM];
      hub_s  = tap[TAP_HUB];
      pci_s  = tap[TAP_PCI];
      usb_s  = tap[TAP_USB];
      ref_s  = tap[TAP_REF];
      apic_s = tap[TAP_APIC];
    end else begin
      cpu_s  = (freq_sel == SEL_N100) ? src_cpu100 : src_cpu66;
      sd_s   = src_sdram;
      hub_s  = src_hub;
      pci_s  = src_pci;
      usb_s  = src_usb;
      ref_s  = src_ref;
      apic_s = apic_norm;
    end
  end
endmodule

// File: rtl/clk_pd_qual.sv
module clk_pd_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  output logic pd_act
);
  localparam int CW = $clog2(QUAL_EDGES + 1);

  logic [SYNC_STAGES-1:0] sync;
  logic [CW-1:0]          cnt;
  logic                   pd_s_n;

  assign pd_s_n = sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync   <= '1;
      cnt    <= '0;
      pd_act <= 1'b0;
    end else begin
      sync <= {sync[SYNC_STAGES-2:0], pd_n};
      if (pd_s_n) begin
        cnt    <= '0;
        pd_act <= 1'b0;
      end else begin
        if (cnt != CW'(QUAL_EDGES)) cnt <= cnt + 1'b1;
        if (cnt == CW'(QUAL_EDGES - 1)) pd_act <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic clk_src,
  input  logic rst_n,
  input  logic en,
  output logic clk_out
);
  logic en_q;

  // enable moves only while the source is low: no shortened high phase
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign clk_out = clk_src & en_q;
endmodule

// File: rtl/clk_mode_gate.sv
module clk_mode_gate
  import clk_mode_gate_pkg::*;
#(
  parameter int NUM_SDRAM   = 8,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_EDGES  = 2
) (
  input  logic                 rst_n,
  input  logic                 tclk,
  input  logic                 src_cpu66,
  input  logic                 src_cpu100,
  input  logic                 src_sdram,
  input  logic                 src_hub,
  input  logic                 src_pci,
  input  logic                 src_usb,
  input  logic                 src_ref,
  input  logic [1:0]           freq_sel,
  input  logic                 apic_strap,
  input  logic                 pd_n,
  input  logic [NUM_SDRAM-1:0] sdram_en,
  output logic                 cpu_clk,
  output logic [NUM_SDRAM-1:0] sdram_clk,
  output logic                 sdram_free_clk,
  output logic                 hub_clk,
  output logic                 pci_clk,
  output logic                 usb_clk,
  output logic                 ref_clk,
  output logic                 apic_clk,
  output logic                 clk_oe,
  output logic                 osc_stop,
  output logic                 vco_stop
);
  localparam int N_GATE = N_FIXED + NUM_SDRAM;

  logic [DIV_STAGES:0] tap;
  logic cpu_src, sd_src, hub_src, pci_src, usb_src, ref_src, apic_src;
  logic strap_q, strap_done, apic_half, apic_norm;
  logic pd_act;
  logic [N_GATE-1:0] gsrc, gen_en, gout;

  clk_test_div #(.STAGES(DIV_STAGES)) u_div (
    .tclk (tclk),
    .rst_n(rst_n),
    .tap  (tap)
  );

  // strap capture on the first reference edge after reset
  always_ff @(posedge src_ref or negedge rst_n) begin
    if (!rst_n) begin
      strap_q    <= 1'b0;
      strap_done <= 1'b0;
    end else if (!strap_done) begin
      strap_q    <= apic_strap;
      strap_done <= 1'b1;
    end
  end

  always_ff @(posedge src_pci or negedge rst_n) begin
    if (!rst_n) apic_half <= 1'b0;
    else        apic_half <= ~apic_half;
  end

  assign apic_norm = strap_q ? src_pci : apic_half;

  clk_src_select #(.STAGES(DIV_STAGES)) u_sel (
    .freq_sel  (freq_sel),
    .tap       (tap),
    .src_cpu66 (src_cpu66),
    .src_cpu100(src_cpu100),
    .src_sdram (src_sdram),
    .src_hub   (src_hub),
    .src_pci   (src_pci),
    .src_usb   (src_usb),
    .src_ref   (src_ref),
    .apic_norm (apic_norm),
    .cpu_s     (cpu_src),
    .sd_s      (sd_src),
    .hub_s     (hub_src),
    .pci_s     (pci_src),
    .usb_s     (usb_src),
    .ref_s     (ref_src),
    .apic_s    (apic_src)
  );

  clk_pd_qual #(.SYNC_STAGES(SYNC_STAGES), .QUAL_EDGES(QUAL_EDGES)) u_pd (
    .clk   (cpu_src),
    .rst_n (rst_n),
    .pd_n  (pd_n),
    .pd_act(pd_act)
  );

  assign gsrc[IDX_CPU]  = cpu_src;
  assign gsrc[IDX_SDF]  = sd_src;
  assign gsrc[IDX_HUB]  = hub_src;
  assign gsrc[IDX_PCI]  = pci_src;
  assign gsrc[IDX_USB]  = usb_src;
  assign gsrc[IDX_REF]  = ref_src;
  assign gsrc[IDX_APIC] = apic_src;

  genvar gi;
  generate
    for (gi = 0; gi < N_GATE; gi++) begin : g_gate
      if (gi >= N_FIXED) begin : g_sd
        assign gsrc[gi]   = sd_src;
        assign gen_en[gi] = ~pd_act & sdram_en[gi - N_FIXED];
        assign sdram_clk[gi - N_FIXED] = gout[gi];
      end else begin : g_fix
        assign gen_en[gi] = ~pd_act;
      end
      clk_gate_cell u_cell (
        .clk_src(gsrc[gi]),
        .rst_n  (rst_n),
        .en     (gen_en[gi]),
        .clk_out(gout[gi])
      );
    end
  endgenerate

  assign cpu_clk        = gout[IDX_CPU];
  assign sdram_free_clk = gout[IDX_SDF];
  assign hub_clk        = gout[IDX_HUB];
  assign pci_clk        = gout[IDX_PCI];
  assign usb_clk        = gout[IDX_USB];
  assign ref_clk        = gout[IDX_REF];
  assign apic_clk       = gout[IDX_APIC];

  assign clk_oe   = (freq_sel != SEL_HIZ);
  assign osc_stop = pd_act;
  assign vco_stop = pd_act;
endmodule

// File: rtl/clk_mode_gate_chk.sv
module clk_mode_gate_chk (
  input logic rst_n,
  input logic cpu_src,
  input logic sd_src,
  input logic src_ref,
  input logic pd_n,
  input logic osc_stop,
  input logic cpu_clk,
  input logic sdram_free_clk,
  input logic strap_q,
  input logic strap_done
);
  logic [1:0] sd_seen;

  always_ff @(negedge sd_src or negedge rst_n) begin
    if (!rst_n)               sd_seen <= 2'd0;
    else if (sd_seen != 2'd2) sd_seen <= sd_seen + 2'd1;
  end

  // R6: stop asserted only after pd_n was low across the sync + qualify window
  assert_pd_qual_R6: assert property (@(posedge cpu_src) disable iff (!rst_n)
    $rose(osc_stop) |-> (!$past(pd_n, 3) && !$past(pd_n, 4)));

  // R8: stop released only after pd_n was seen high through the synchroniser
  assert_pd_release_R8: assert property (@(posedge cpu_src) disable iff (!rst_n)
    $fell(osc_stop) |-> $past(pd_n, 3));

  // R7: one full CPU low phase after acceptance, the CPU high phase is gone
  assert_cpu_held_R7: assert property (@(negedge cpu_src) disable iff (!rst_n)
    (osc_stop && $past(osc_stop)) |-> !cpu_clk);

  // R9: the free-running memory clock is high in every high phase outside power-down
  assert_free_runs_R9: assert property (@(negedge sd_src) disable iff (!rst_n)
    (sd_seen == 2'd2 && !$past(osc_stop)) |-> sdram_free_clk);

  // R5: the captured strap never moves once taken
  assert_strap_hold_R5: assert property (@(posedge src_ref) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> $stable(strap_q));
endmodule

bind clk_mode_gate clk_mode_gate_chk u_chk (
  .rst_n         (rst_n),
  .cpu_src       (cpu_src),
  .sd_src        (sd_src),
  .src_ref       (src_ref),
  .pd_n          (pd_n),
  .osc_stop      (osc_stop),
  .cpu_clk       (cpu_clk),
  .sdram_free_clk(sdram_free_clk),
  .strap_q       (strap_q),
  .strap_done    (strap_done)
);

// File: tb/tb_clk_mode_gate.sv
`timescale 1ns/1ps
module tb_clk_mode_gate;
  localparam int NS    = 8;
  localparam int N_OBS = NS + 7;
  // obs index: 0..7 sdram, 8 free, 9 cpu, 10 hub, 11 pci, 12 usb, 13 ref, 14 apic
  localparam int O_FREE = 8, O_CPU = 9, O_HUB = 10, O_PCI = 11, O_USB = 12, O_REF = 13, O_APIC = 14;

  logic tclk = 1'b0;
  logic s66 = 1'b0, s100 = 1'b0, ssd = 1'b0, shub = 1'b0, spci = 1'b0, susb = 1'b0, sref = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] freq_sel = 2'b11;
  logic apic_strap = 1'b0;
  logic pd_n = 1'b1;
  logic [NS-1:0] sdram_en = '1;
  logic cpu_clk, sdram_free_clk, hub_clk, pci_clk, usb_clk, ref_clk, apic_clk;
  logic clk_oe, osc_stop, vco_stop;
  logic [NS-1:0] sdram_clk;
  logic [N_OBS-1:0] obs;

  int tests = 0, fails = 0;
  bit done = 0;
  int cnt_w [N_OBS];
  int runt_w [N_OBS];
  int snap [N_OBS];
  int delta [N_OBS];

  always #4 tclk = ~tclk;
  initial begin #0.3; forever #7.5  s66  = ~s66;  end
  initial begin #0.7; forever #5.0  s100 = ~s100; end
  initial begin #0.6; forever #5.0  ssd  = ~ssd;  end
  initial begin #0.2; forever #7.5  shub = ~shub; end
  initial begin #0.4; forever #15.0 spci = ~spci; end
  initial begin #0.1; forever #10.5 susb = ~susb; end
  initial begin #0.9; forever #35.0 sref = ~sref; end

  clk_mode_gate #(.NUM_SDRAM(NS)) dut (
    .rst_n(rst_n), .tclk(tclk),
    .src_cpu66(s66), .src_cpu100(s100), .src_sdram(ssd), .src_hub(shub),
    .src_pci(spci), .src_usb(susb), .src_ref(sref),
    .freq_sel(freq_sel), .apic_strap(apic_strap), .pd_n(pd_n), .sdram_en(sdram_en),
    .cpu_clk(cpu_clk), .sdram_clk(sdram_clk), .sdram_free_clk(sdram_free_clk),
    .hub_clk(hub_clk), .pci_clk(pci_clk), .usb_clk(usb_clk), .ref_clk(ref_clk),
    .apic_clk(apic_clk), .clk_oe(clk_oe), .osc_stop(osc_stop), .vco_stop(vco_stop)
  );

  assign obs = {apic_clk, ref_clk, usb_clk, pci_clk, hub_clk, cpu_clk, sdram_free_clk, sdram_clk};

  genvar g;
  generate
    for (g = 0; g < N_OBS; g++) begin : g_mon
      int n = 0;
      int runts = 0;
      realtime tr = 0.0;
      always @(posedge obs[g]) begin n++; tr = $realtime; end
      always @(negedge obs[g]) if (tr > 0.0 && ($realtime - tr) < 4.5) runts++;
      assign cnt_w[g]  = n;
      assign runt_w[g] = runts;
    end
  endgenerate

  task automatic check(input string req, input int act, input int exp, input int tol);
    tests++;
    if (act > exp + tol || act < exp - tol) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input realtime w);
    for (int i = 0; i < N_OBS; i++) snap[i] = cnt_w[i];
    #w;
    for (int i = 0; i < N_OBS; i++) delta[i] = cnt_w[i] - snap[i];
  endtask

  function automatic int runt_total();
    int s = 0;
    for (int i = 0; i < N_OBS; i++) s += runt_w[i];
    return s;
  endfunction

  task automatic settle(input int ns);
    @(negedge tclk);
    #(ns);
  endtask

  task automatic t_reset();
    #50;
    check("R1 outputs low in reset", int'(obs), 0, 0);
    check("R1 osc_stop low in reset", int'(osc_stop), 0, 0);
    check("R1 vco_stop low in reset", int'(vco_stop), 0, 0);
    @(negedge tclk); rst_n = 1'b1;
    settle(200);
  endtask

  task automatic t_normal100();
    @(negedge tclk); freq_sel = 2'b11;
    settle(100);
    check("R2 clk_oe high for 11", int'(clk_oe), 1, 0);
    measure(600);
    check("R3 cpu 100", delta[O_CPU], 60, 1);
    check("R3 sdram0", delta[0], 60, 1);
    check("R3 sdram free", delta[O_FREE], 60, 1);
    check("R3 hub", delta[O_HUB], 40, 1);
    check("R3 pci", delta[O_PCI], 20, 1);
    check("R3 usb", delta[O_USB], 29, 1);
    check("R3 ref", delta[O_REF], 9, 1);
    check("R5 apic half rate (strap 0)", delta[O_APIC], 10, 1);
  endtask

  task automatic t_normal66();
    @(negedge tclk); freq_sel = 2'b10;
    settle(100);
    measure(600);
    check("R3 cpu 66", delta[O_CPU], 40, 1);
    check("R3 pci in 66 mode", delta[O_PCI], 20, 1);
  endtask

  task automatic t_test_mode();
    @(negedge tclk); freq_sel = 2'b01;
    settle(100);
    check("R2 clk_oe high for 01", int'(clk_oe), 1, 0);
    measure(800);
    check("R4 cpu tclk/2", delta[O_CPU], 50, 1);
    check("R4 sdram tclk/4", delta[3], 25, 1);
    check("R4 hub tclk/4", delta[O_HUB], 25, 1);
    check("R4 pci tclk/8", delta[O_PCI], 12, 1);
    check("R4 usb tclk/2", delta[O_USB], 50, 1);
    check("R4 ref tclk", delta[O_REF], 100, 1);
    check("R4 apic tclk/16", delta[O_APIC], 6, 1);
  endtask

  task automatic t_hiz();
    @(negedge tclk); freq_sel = 2'b00;
    settle(20);
    check("R2 clk_oe low for 00", int'(clk_oe), 0, 0);
    @(negedge tclk); freq_sel = 2'b11;
    settle(20);
    check("R2 clk_oe back high", int'(clk_oe), 1, 0);
  endtask

  task automatic t_sdram_en();
    @(negedge tclk); freq_sel = 2'b11; sdram_en = 8'hA5;
    settle(100);
    measure(600);
    for (int i = 0; i < NS; i++)
      check($sformatf("R9 sdram_clk[%0d] with en=%0d", i, sdram_en[i]), delta[i], sdram_en[i] ? 60 : 0, sdram_en[i] ? 1 : 0);
    check("R9 free clock ignores enables", delta[O_FREE], 60, 1);
  endtask

  task automatic t_power_down();
    int r0;
    @(negedge tclk); sdram_en = '1;
    settle(100);
    r0 = runt_total();
    @(negedge tclk); pd_n = 1'b0;
    #12;
    check("R6 no stop before qualification", int'(osc_stop), 0, 0);
    #100;
    check("R6 osc_stop asserted", int'(osc_stop), 1, 0);
    check("R6 vco_stop asserted", int'(vco_stop), 1, 0);
    sdram_en = 8'h0F;
    measure(300);
    for (int i = 0; i < N_OBS; i++)
      check($sformatf("R7 output %0d held low", i), delta[i], 0, 0);
    check("R7 output levels low", int'(obs), 0, 0);
    @(negedge tclk); pd_n = 1'b1;
    settle(100);
    check("R8 osc_stop released", int'(osc_stop), 0, 0);
    check("R8 vco_stop released", int'(vco_stop), 0, 0);
    measure(600);
    check("R8 cpu resumes", delta[O_CPU], 60, 1);
    check("R8 pci resumes", delta[O_PCI], 20, 1);
    check("R8 sdram0 resumes", delta[0], 60, 1);
    check("R9 disabled sdram7 stays low after exit", delta[7], 0, 0);
    check("R7 no runt pulses across entry and exit", runt_total() - r0, 0, 0);
  endtask

  task automatic t_strap();
    @(negedge tclk); apic_strap = 1'b1;
    settle(200);
    measure(600);
    check("R5 strap change ignored without reset", delta[O_APIC], 10, 1);
    @(negedge tclk); rst_n = 1'b0;
    #40;
    @(negedge tclk); rst_n = 1'b1;
    settle(200);
    measure(600);
    check("R5 strap 1 gives pci rate", delta[O_APIC], 20, 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_normal100();
    t_normal66();
    t_test_mode();
    t_hiz();
    t_sdram_en();
    t_power_down();
    t_strap();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule